// File: doc/BRIEF.md
# Six-mode timer counting engine

This block is the down-counting core of one interval timer channel. It keeps a count register of `W` bits (16 by default) that counts in plain binary or as four packed decimal digits. It steps once for each cycle in which the count-enable tick is high, and drives the channel's output waveform in one of six modes. The host-side byte interface sits outside this block. That interface presents the selected mode, the binary/decimal choice and the reload value as levels. It raises a one-cycle strobe when a control word is written and another when a complete count has been written.

The engine is a five-state machine. `ST_IDLE` follows reset or a control write; no count is pending. `ST_ARMED` holds a written count until the gate has a rising edge (hardware-triggered modes only). `ST_RELOAD` copies the reload value into the counter on the next tick. `ST_RUN` decrements. `ST_AFTER` is entered at terminal count in the one-shot modes and keeps decrementing with the output high. The transitions are: control write → `ST_IDLE`. Count write → `ST_RELOAD` in modes 0 and 4. Count write → `ST_ARMED` in modes 1 and 5. Count write → `ST_RELOAD` in modes 2 and 3, unless the engine is already in `ST_RUN`. Gate rise in `ST_ARMED` (modes 1, 5) or in `ST_RUN` (modes 2, 3) → `ST_RELOAD`. Tick in `ST_RELOAD` → `ST_RUN`. Terminal count in `ST_RUN` (modes 0, 1, 4, 5) → `ST_AFTER`. The gate is compared with a registered copy of itself to find rising edges. `loaded_o` pulses whenever the counter takes the reload value, so the outer logic can clear its null-count flag.

Top module: `tmr_engine`

## Requirements
- R1: After reset, `out_o` is 0, `count_o` is 0 and `loaded_o` is 0.
- R2: A control write clears `count_o` to 0 and stops counting until a count is written. On the next cycle `out_o` is 0 if the mode is 0, and 1 for any other mode.
- R3: Mode 0: a count write drives `out_o` low. The next tick loads the count. With count N, `out_o` rises on the (N+1)-th tick after the write, counting the load tick. `out_o` then stays high while the counter keeps decrementing and wrapping (binary 0 steps to 0xFFFF).
- R4: The counter changes only on a tick or a control write. With the gate low, counting halts in modes 0, 2, 3 and 4. Modes 1 and 5 keep counting whatever the gate level.
- R5: Modes 1 and 5: a written count waits, with `count_o` unchanged and `out_o` high, until a rising edge of the gate. It then loads on the next tick. Mode 1 drives `out_o` low on the trigger, and `out_o` rises N+1 ticks later.
- R6: Mode 2: `out_o` is high and falls for exactly one tick when the count reaches 1. The next tick reloads and raises `out_o`. The first period is N ticks including the load tick. Later high phases are N-1 ticks.
- R7: Mode 3: the counter steps by two and `out_o` toggles on each reload. An even N gives N/2 ticks per phase. An odd N gives (N+1)/2 ticks high and (N-1)/2 ticks low. The very first high phase is one tick longer, because it includes the load tick.
- R8: Modes 4 and 5: `out_o` stays high, falls N+1 ticks after loading begins, stays low for exactly one tick, and then stays high.
- R9: A count of 0 stands for 65536 in binary and 10000 in decimal. In mode 0 these give 65537 and 10001 ticks to the rise of `out_o`.
- R10: Modes 2 and 3: a count write while running does not restart the count, and the new value is used at the next reload. A rising gate forces a reload. A low gate forces `out_o` high.
- R11: With `bcd_i` = 1 the counter steps as four decimal digits, each held in four bits with the lowest digit in bits 3:0. It borrows across digits (0x0100 steps to 0x0099) and wraps from 0x0000 to 0x9999.
- R12: Mode values 6 and 7 behave exactly as modes 2 and 3.
- R13: `loaded_o` is high for one cycle each time the counter takes the reload value, and `count_o` then equals that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Count enable, one step per high cycle |
| gate_i | input | 1 | Gate level |
| mode_i | input | 3 | Operating mode 0 to 7 |
| bcd_i | input | 1 | 1 selects four-digit decimal counting |
| reload_i | input | W | Count value written by the host |
| count_wr_i | input | 1 | Strobe: a complete count has been written |
| ctrl_wr_i | input | 1 | Strobe: a control word has been written |
| out_o | output | 1 | Output waveform |
| count_o | output | W | Live counter value |
| loaded_o | output | 1 | Counter took the reload value this cycle |

## Verification
A wrong state shows up as a phase of the wrong length in `out_o`. The bench therefore measures every phase in ticks, so a misplaced reload or terminal decision is caught on the first edge it affects. A state machine stuck in `ST_ARMED` or `ST_IDLE` leaves `count_o` frozen, and this is visible on the tick after the expected load. A decrementer fault in decimal mode shows on the first digit borrow or wrap. The tests place those borrows and wraps within three ticks of a load.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RELOAD,
        ST_RUN,
        ST_AFTER
    } tmr_state_e;

    // Modes 6 and 7 fold onto 2 and 3.
    function automatic logic [2:0] eff_mode(input logic [2:0] m);
        return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

    // Modes in which a low gate suspends counting.
    function automatic logic gate_halts(input logic [2:0] em);
        return (em == 3'd0) || (em == 3'd2) || (em == 3'd3) || (em == 3'd4);
    endfunction

endpackage

// File: rtl/tmr_step.sv
`timescale 1ns/1ps
module tmr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         two_i,
    input  logic         bcd_i,
    output logic [W-1:0] res_o,
    output logic         wrap_o
);
    localparam int DIG = W / 4;

    logic [DIG:0]   brw;
    logic [W-1:0]   dec_res;
    logic [W-1:0]   bin_res;
    logic [1:0]     amt0;

    assign amt0   = two_i ? 2'd2 : 2'd1;
    assign brw[0] = 1'b0;

    for (genvar g = 0; g < DIG; g++) begin : g_digit
        logic [3:0] d;
        logic [3:0] sub;
        assign d   = val_i[g*4 +: 4];
        assign sub = {3'b000, brw[g]} + ((g == 0) ? {2'b00, amt0} : 4'd0);
        assign brw[g+1] = (d < sub);
        assign dec_res[g*4 +: 4] = (d < sub) ? 4'(d + 4'd10 - sub) : 4'(d - sub);
    end

    assign bin_res = val_i - W'(amt0);
    assign res_o   = bcd_i ? dec_res : bin_res;
    assign wrap_o  = bcd_i ? brw[DIG] : (val_i < W'(amt0));
endmodule

// File: rtl/tmr_gate_edge.sv
`timescale 1ns/1ps
module tmr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    assign rise_o = gate_i && !gate_q;
endmodule

// File: rtl/tmr_engine.sv
`timescale 1ns/1ps
module tmr_engine
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         gate_i,
    input  logic [2:0]   mode_i,
    input  logic         bcd_i,
    input  logic [W-1:0] reload_i,
    input  logic         count_wr_i,
    input  logic         ctrl_wr_i,
    output logic         out_o,
    output logic [W-1:0] count_o,
    output logic         loaded_o
);
    localparam int             DIG     = W / 4;
    localparam logic [W-1:0]   CNT_ONE = W'(1);
    localparam logic [W-1:0]   CNT_TWO = W'(2);
    localparam logic [W-1:0]   NINES   = {DIG{4'h9}};

    tmr_state_e   st_q, st_n;
    logic [W-1:0] cnt_q, cnt_n, even_cnt, step_val;
    logic         out_q, out_n, ld_q, ld_n;
    logic [2:0]   em;
    logic         halt, rise, sq, wrap;

    assign em       = eff_mode(mode_i);
    assign halt     = gate_halts(em) && !gate_i;
    assign sq       = (em == 3'd3);
    assign even_cnt = {cnt_q[W-1:1], 1'b0};

    tmr_gate_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_i),
        .rise_o (rise)
    );

    tmr_step #(.W(W)) u_step (
        .val_i  (sq ? even_cnt : cnt_q),
        .two_i  (sq),
        .bcd_i  (bcd_i),
        .res_o  (step_val),
        .wrap_o (wrap)
    );

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        out_n = out_q;
        ld_n  = 1'b0;
        if (ctrl_wr_i) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
            out_n = (em != 3'd0);
        end else if (count_wr_i) begin
            unique case (em)
                3'd0: begin
                    st_n  = ST_RELOAD;
                    out_n = 1'b0;
                end
                3'd1, 3'd5: st_n = ST_ARMED;
                3'd2, 3'd3: if (st_q != ST_RUN) st_n = ST_RELOAD;
                default:    st_n = ST_RELOAD;
            endcase
        end else if (rise && ((st_q == ST_ARMED && (em == 3'd1 || em == 3'd5)) ||
                              (st_q == ST_RUN   && (em == 3'd2 || em == 3'd3)))) begin
            st_n = ST_RELOAD;
            if (em == 3'd1) out_n = 1'b0;
        end else if (tick_i) begin
            unique case (st_q)
                ST_RELOAD: begin
                    cnt_n = reload_i;
                    ld_n  = 1'b1;
                    st_n  = ST_RUN;
                end
                ST_RUN: if (!halt) begin
                    if (em == 3'd2) begin
                        if (cnt_q == CNT_ONE) begin
                            out_n = 1'b1;
                            cnt_n = reload_i;
                            ld_n  = 1'b1;
                        end else begin
                            cnt_n = step_val;
                            if (cnt_q == CNT_TWO) out_n = 1'b0;
                        end
                    end else if (sq) begin
                        if (cnt_q[0] && out_q) begin
                            cnt_n = even_cnt;
                        end else if (even_cnt == CNT_TWO) begin
                            out_n = !out_q;
                            cnt_n = reload_i;
                            ld_n  = 1'b1;
                        end else begin
                            cnt_n = step_val;
                        end
                    end else if (cnt_q == CNT_ONE) begin
                        cnt_n = '0;
                        out_n = (em <= 3'd1);
                        st_n  = ST_AFTER;
                    end else begin
                        cnt_n = step_val;
                    end
                end
                ST_AFTER: if (!halt) begin
                    cnt_n = step_val;
                    out_n = 1'b1;
                end
                default: ;
            endcase
        end
        if ((em == 3'd2 || em == 3'd3) && !gate_i) out_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
            ld_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            out_q <= out_n;
            ld_q  <= ld_n;
        end
    end

    assign out_o    = out_q;
    assign count_o  = cnt_q;
    assign loaded_o = ld_q;

    // R2: a control write sets the output level and clears the count
    p_ctrl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i && eff_mode(mode_i) == 3'd0 |=> !out_o && count_o == '0);
    p_ctrl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr_i && eff_mode(mode_i) != 3'd0 |=> out_o && count_o == '0);
    // R3: a count write in mode 0 pulls the output low
    p_m0_write_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_i && count_wr_i && em == 3'd0 |=> !out_o);
    // R4: no tick, no movement
    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !ctrl_wr_i |=> $stable(count_o));
    p_gate_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !gate_i && (em == 3'd0 || em == 3'd4) && st_q == ST_RUN &&
        !ctrl_wr_i && !count_wr_i |=> $stable(count_o));
    // R8: the strobe lasts one tick
    p_strobe_one_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_AFTER && !out_o && tick_i && !halt && !ctrl_wr_i && !count_wr_i
        |=> out_o);
    // R10: low gate forces the output high in the periodic modes
    p_gate_low_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (em == 3'd2 || em == 3'd3) && !gate_i |=> out_o);
    // R11: wrap from zero lands on all nines or all ones
    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_AFTER && tick_i && !halt && !ctrl_wr_i && !count_wr_i && wrap
        |=> count_o == ($past(bcd_i) ? NINES : '1));
    // R13: a load pulse carries the reload value
    p_load_value_r13: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_o |-> count_o == $past(reload_i));
endmodule

// File: tb/tmr_engine_tb.sv
`timescale 1ns/1ps
module tmr_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick, gate, bcd, count_wr, ctrl_wr;
    logic [2:0]  mode;
    logic [15:0] reload;
    logic        out_o, loaded_o;
    logic [15:0] count_o;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;

    always #2.5 clk = !clk;

    tmr_engine #(.W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate), .mode_i(mode),
        .bcd_i(bcd), .reload_i(reload), .count_wr_i(count_wr), .ctrl_wr_i(ctrl_wr),
        .out_o(out_o), .count_o(count_o), .loaded_o(loaded_o)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic        bc;
        logic        trig;
        logic [15:0] rl;
        logic        init;
        logic [16:0] p1;
        logic [16:0] p2;
        logic [16:0] p3;
    } row_t;

    // phase lengths in ticks; 0 means the level must hold from then on
    localparam row_t ROWS [13] = '{
        '{3'd0, 1'b0, 1'b0, 16'd5,     1'b0, 17'd6,     17'd0, 17'd0},
        '{3'd2, 1'b0, 1'b0, 16'd4,     1'b1, 17'd4,     17'd1, 17'd3},
        '{3'd3, 1'b0, 1'b0, 16'd7,     1'b1, 17'd5,     17'd3, 17'd4},
        '{3'd3, 1'b0, 1'b0, 16'd6,     1'b1, 17'd4,     17'd3, 17'd3},
        '{3'd4, 1'b0, 1'b0, 16'd3,     1'b1, 17'd4,     17'd1, 17'd0},
        '{3'd6, 1'b0, 1'b0, 16'd3,     1'b1, 17'd3,     17'd1, 17'd2},
        '{3'd7, 1'b1, 1'b0, 16'h0011,  1'b1, 17'd7,     17'd5, 17'd6},
        '{3'd2, 1'b1, 1'b0, 16'h0010,  1'b1, 17'd10,    17'd1, 17'd9},
        '{3'd1, 1'b0, 1'b1, 16'd3,     1'b0, 17'd4,     17'd0, 17'd0},
        '{3'd5, 1'b0, 1'b1, 16'd3,     1'b1, 17'd4,     17'd1, 17'd0},
        '{3'd3, 1'b1, 1'b0, 16'h1001,  1'b1, 17'd502,   17'd500, 17'd501},
        '{3'd0, 1'b1, 1'b0, 16'h0000,  1'b0, 17'd10001, 17'd0, 17'd0},
        '{3'd0, 1'b0, 1'b0, 16'h0000,  1'b0, 17'd65537, 17'd0, 17'd0}
    };

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string row_tag(input logic [2:0] md, input logic [15:0] rl);
        if (rl == 16'd0) return "R9";
        case (md)
            3'd0:       return "R3";
            3'd1:       return "R5";
            3'd2:       return "R6";
            3'd3:       return "R7";
            3'd4, 3'd5: return "R8";
            default:    return "R12";
        endcase
    endfunction

    // all tasks start and end at a falling edge
    task automatic ctrl_write(input logic [2:0] md, input logic bc);
        mode = md; bcd = bc; ctrl_wr = 1'b1; tick = 1'b0;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic count_write(input logic [15:0] v);
        reload = v; count_wr = 1'b1; tick = 1'b0;
        @(negedge clk);
        count_wr = 1'b0;
    endtask

    task automatic run(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic phase(input string tag, input int exp);
        logic s;
        int   n;
        logic moved;
        s = out_o; n = 0; moved = 1'b0;
        if (exp == 0) begin
            repeat (40) begin
                @(negedge clk);
                if (out_o != s) moved = 1'b1;
            end
            chk(tag, "level holds", int'(moved), 0);
        end else begin
            for (int i = 0; i < exp + 4; i++) begin
                @(negedge clk);
                n++;
                if (out_o != s) break;
            end
            chk(tag, "phase ticks", n, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0; gate = 1'b1; bcd = 1'b0; count_wr = 1'b0;
        ctrl_wr = 1'b0; mode = 3'd0; reload = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1", "out", int'(out_o), 0);
        chk("R1", "count", int'(count_o), 0);
        chk("R1", "loaded", int'(loaded_o), 0);
        @(negedge clk);

        foreach (ROWS[k]) begin
            string tg;
            tg = row_tag(ROWS[k].md, ROWS[k].rl);
            ctrl_write(ROWS[k].md, ROWS[k].bc);
            chk("R2", "out after control", int'(out_o), (ROWS[k].md == 3'd0) ? 0 : 1);
            count_write(ROWS[k].rl);
            tick = 1'b1;
            if (ROWS[k].trig) begin
                repeat (5) @(negedge clk);
                chk("R5", "armed count", int'(count_o), 0);
                chk("R5", "armed out", int'(out_o), 1);
                gate = 1'b0;
                @(negedge clk);
                gate = 1'b1;
                @(negedge clk);
            end
            chk(tg, "initial out", int'(out_o), int'(ROWS[k].init));
            phase(tg, int'(ROWS[k].p1));
            if (ROWS[k].p2 != 0) begin
                phase(tg, int'(ROWS[k].p2));
                phase(tg, int'(ROWS[k].p3));
            end else begin
                phase(tg, 0);
            end
        end

        // R4: tick and gate control of the count
        ctrl_write(3'd0, 1'b0);
        count_write(16'd10);
        run(3);
        chk("R4", "count after 3 ticks", int'(count_o), 8);
        tick = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4", "count without tick", int'(count_o), 8);
        gate = 1'b0;
        run(3);
        chk("R4", "count with gate low mode 0", int'(count_o), 8);
        gate = 1'b1;
        run(1);
        chk("R4", "count after gate high", int'(count_o), 7);

        // R2: control write mid-count stops counting
        ctrl_write(3'd0, 1'b0);
        run(5);
        chk("R2", "count after control", int'(count_o), 0);
        chk("R2", "out after control", int'(out_o), 0);

        // R4: mode 5 keeps counting with the gate low
        ctrl_write(3'd5, 1'b0);
        count_write(16'd10);
        tick = 1'b1;
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
        gate = 1'b0;
        run(3);
        chk("R4", "mode 5 count with gate low", int'(count_o), 8);
        gate = 1'b1;

        // R13 / R10: reload pulses and mid-run rewrite in mode 2
        ctrl_write(3'd2, 1'b0);
        count_write(16'd10);
        run(1);
        chk("R13", "loaded on load tick", int'(loaded_o), 1);
        chk("R13", "count on load tick", int'(count_o), 10);
        run(1);
        chk("R13", "loaded drops", int'(loaded_o), 0);
        chk("R10", "count before rewrite", int'(count_o), 9);
        count_write(16'd4);
        chk("R10", "count across rewrite", int'(count_o), 9);
        run(1);
        chk("R10", "no restart on rewrite", int'(count_o), 8);
        run(8);
        chk("R10", "new value at reload", int'(count_o), 4);
        chk("R13", "loaded at reload", int'(loaded_o), 1);
        run(3);
        chk("R6", "low at count 1", int'(out_o), 0);
        gate = 1'b0;
        @(negedge clk);
        chk("R10", "gate low forces high", int'(out_o), 1);
        chk("R4", "mode 2 halted", int'(count_o), 1);
        gate = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "gate rise reloads", int'(count_o), 4);
        chk("R13", "loaded after gate rise", int'(loaded_o), 1);

        // R11: decimal borrow and wrap
        ctrl_write(3'd0, 1'b1);
        count_write(16'h0100);
        run(2);
        chk("R11", "digit borrow", int'(count_o), 16'h0099);
        ctrl_write(3'd0, 1'b1);
        count_write(16'h0002);
        run(3);
        chk("R11", "terminal count", int'(count_o), 0);
        chk("R3", "out at terminal", int'(out_o), 1);
        run(1);
        chk("R11", "wrap to nines", int'(count_o), 16'h9999);
        run(1);
        chk("R11", "after wrap", int'(count_o), 16'h9998);

        // R3: binary wrap after terminal count
        ctrl_write(3'd0, 1'b0);
        count_write(16'd1);
        run(3);
        chk("R3", "binary wrap", int'(count_o), 16'hFFFF);
        chk("R3", "out stays high", int'(out_o), 1);

        tick = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule